// File: doc/BRIEF.md
# CAN Operating-Mode and Pin Controller

This block sits between a CAN protocol engine and the two bus pins. It applies three operating modes chosen by software: module disable, internal loop-back and listen-only. It decides what the transmit pin shows and which bit stream the engine receives. It overrides the acknowledge bit where a mode calls for it. It tells the engine when to freeze its error counters and when to act as error passive. It reports a bit-zero error for frames that no other station acknowledged.

The mode request bits are taken in only while the engine reports bus idle, so a frame in flight always finishes under the mode it started with. Disabling the module drops the clock enable to the engine at once. A low-power acknowledge follows after the enable has passed a two-stage synchronizer. While disabled, the register port still works, but accesses to the free-running timer, the error-counter register and the message-buffer window are refused. A refused access is not forwarded, reads zero, and raises a one-cycle access error.

Top module: `can_mode_ctrl`

## Requirements
- R1: The active mode is loaded from the request bits at a rising clock edge only when `eng_idle_i` is 1, and takes effect from that edge. While `eng_idle_i` is 0 the active mode keeps its value.
- R2: With loop-back active, `eng_rx_o` equals `eng_tx_i` and does not depend on `pin_rx_i`, and `pin_tx_o` is 1 (recessive).
- R3: With loop-back active and `eng_ack_slot_i` high, `eng_rx_o` is 0 (dominant), so the node's own frame is acknowledged.
- R4: With listen-only active, `pin_tx_o` is 1 whatever `eng_tx_i` is, and `cnt_freeze_o` and `force_passive_o` are both 1. Both are 0 when listen-only is not active.
- R5: With listen-only active and loop-back inactive, an ACK-slot strobe that sees `pin_rx_i` = 1 gives `bit0_err_o` = 1 for exactly the next cycle. A strobe that sees `pin_rx_i` = 0 gives no error.
- R6: With loop-back and listen-only both active, the receive routing and ACK override follow loop-back. `pin_tx_o` stays 1, counter freeze and error-passive stay 1, and no bit-zero error is raised.
- R7: With no mode active, `pin_tx_o` equals `eng_tx_i` and `eng_rx_o` equals `pin_rx_i`. After reset no mode is active, `clk_en_o` is 1, and `lp_ack_o`, `bit0_err_o` and `acc_err_o` are 0.
- R8: `clk_en_o` is the inverse of the active disable bit and changes with it. `lp_ack_o` follows the inverse of `clk_en_o` three clock edges after the edge that loaded the mode. While disabled, `pin_tx_o` is 1.
- R9: While disabled, an access to byte address `TMR_ADDR` (default 0x008), `ECR_ADDR` (default 0x01C) or the range `MB_LO`..`MB_HI` (default 0x080..0x17F) is refused. A refused access has `acc_valid_o` 0 and `acc_rdata_o` 0 in the same cycle, and `acc_err_o` is 1 for the following cycle only. All other addresses, and every address while enabled, are forwarded with read data passed through and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_disable_i | input | 1 | Requested module-disable bit |
| cfg_loop_i | input | 1 | Requested loop-back bit |
| cfg_listen_i | input | 1 | Requested listen-only bit |
| eng_idle_i | input | 1 | Engine reports the bus idle |
| eng_tx_i | input | 1 | Engine transmit bit stream |
| eng_ack_slot_i | input | 1 | Strobe at the sample point of the ACK slot |
| eng_rx_o | output | 1 | Receive bit stream given to the engine |
| pin_rx_i | input | 1 | Receive pin from the transceiver |
| pin_tx_o | output | 1 | Transmit pin to the transceiver |
| bit0_err_o | output | 1 | One-cycle pulse: unacknowledged frame seen in listen-only |
| cnt_freeze_o | output | 1 | Holds the engine's error counters |
| force_passive_o | output | 1 | Makes the engine act as error passive |
| clk_en_o | output | 1 | Clock enable for the engine |
| lp_ack_o | output | 1 | Low-power acknowledge |
| acc_valid_i | input | 1 | Register access request |
| acc_addr_i | input | ADDR_W | Register byte address |
| acc_rdata_i | input | DATA_W | Read data from the register file |
| acc_valid_o | output | 1 | Access forwarded to the register file |
| acc_rdata_o | output | DATA_W | Read data returned to the bus |
| acc_err_o | output | 1 | One-cycle pulse for a refused access |

## Verification
Pin routing, ACK override, freeze, error-passive and access gating are combinational from the active mode. The bench checks them at the falling edge after the inputs change, and one falling edge after the loading clock edge when a mode change is involved. The bit-zero error and the access error are registered, so they are sampled at the falling edge after the next rising edge, and once more one cycle later to show the pulse has ended. The low-power acknowledge is sampled after the second loading-edge-relative edge, where it must still hold its old value, and after the third, where it must have changed. This is done for entry and for exit.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef struct packed {
        logic dis;
        logic loop;
        logic listen;
    } can_mode_t;

    localparam can_mode_t MODE_RESET = '{dis: 1'b0, loop: 1'b0, listen: 1'b0};

    typedef enum logic [1:0] {
        RX_FROM_PIN  = 2'd0,
        RX_FROM_TX   = 2'd1,
        RX_FORCE_DOM = 2'd2
    } rx_src_e;

    // Loop-back wins the receive routing; ACK slot forced dominant there.
    function automatic rx_src_e pick_rx(can_mode_t m, logic ack_slot);
        if (m.loop) begin
            return ack_slot ? RX_FORCE_DOM : RX_FROM_TX;
        end
        return RX_FROM_PIN;
    endfunction

    // Any non-normal mode keeps the external transmit pin recessive.
    function automatic logic tx_quiet(can_mode_t m);
        return m.dis | m.loop | m.listen;
    endfunction

    function automatic logic addr_in(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/can_mode_latch.sv
module can_mode_latch
    import can_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      idle_i,
    input  can_mode_t req_i,
    output can_mode_t mode_o
);

    can_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (idle_i) begin
            mode_q <= req_i;
        end
    end

    assign mode_o = mode_q;

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !idle_i |=> $stable(mode_q)); // R1

endmodule

// File: rtl/can_pin_route.sv
module can_pin_route
    import can_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  can_mode_t mode_i,
    input  logic      eng_tx_i,
    input  logic      ack_slot_i,
    input  logic      pin_rx_i,
    output logic      pin_tx_o,
    output logic      eng_rx_o,
    output logic      bit0_err_o,
    output logic      cnt_freeze_o,
    output logic      force_passive_o
);

    rx_src_e rx_src;
    logic    bit0_q;
    logic    no_ack_seen;

    assign rx_src = pick_rx(mode_i, ack_slot_i);

    always_comb begin
        unique case (rx_src)
            RX_FROM_TX:   eng_rx_o = eng_tx_i;
            RX_FORCE_DOM: eng_rx_o = 1'b0;
            default:      eng_rx_o = pin_rx_i;
        endcase
    end

    assign pin_tx_o        = tx_quiet(mode_i) ? 1'b1 : eng_tx_i;
    assign cnt_freeze_o    = mode_i.listen;
    assign force_passive_o = mode_i.listen;

    // Monitor only: a recessive ACK slot means nobody acknowledged.
    assign no_ack_seen = mode_i.listen & ~mode_i.loop & ack_slot_i & pin_rx_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit0_q <= 1'b0;
        end else begin
            bit0_q <= no_ack_seen;
        end
    end

    assign bit0_err_o = bit0_q;

    AST_BIT0_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bit0_err_o |-> $past(mode_i.listen && !mode_i.loop && ack_slot_i && pin_rx_i)); // R5

    AST_LOOP_IGNORES_PIN: assert property (@(posedge clk) disable iff (rst)
        (mode_i.loop && !ack_slot_i) |-> (eng_rx_o == eng_tx_i)); // R2

endmodule

// File: rtl/can_lp_hsk.sv
module can_lp_hsk #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dis_i,
    output logic clk_en_o,
    output logic lp_ack_o
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;

    assign clk_en_o = ~dis_i;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= clk_en_o;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[TOP-1:0], clk_en_o};
            end
        end
    endgenerate

    assign lp_ack_o = ~sync_q[TOP];

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            AST_ACK_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
                $rose(lp_ack_o) |-> $past(!clk_en_o, 2)); // R8
            AST_ACK_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
                $fell(lp_ack_o) |-> $past(clk_en_o, 2)); // R8
        end
    endgenerate

endmodule

// File: rtl/can_acc_gate.sv
module can_acc_gate
    import can_mode_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [31:0] TMR_ADDR = 32'h008,
    parameter logic [31:0] ECR_ADDR = 32'h01C,
    parameter logic [31:0] MB_LO    = 32'h080,
    parameter logic [31:0] MB_HI    = 32'h17F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dis_i,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    logic [31:0] addr32;
    logic        guarded;
    logic        refuse;
    logic        err_q;

    assign addr32  = 32'(addr_i);
    assign guarded = (addr32 == TMR_ADDR) || (addr32 == ECR_ADDR) ||
                     addr_in(addr32, MB_LO, MB_HI);
    assign refuse  = dis_i & guarded;

    assign valid_o = valid_i & ~refuse;
    assign rdata_o = refuse ? '0 : rdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= valid_i & refuse;
        end
    end

    assign err_o = err_q;

    AST_ERR_ONLY_DISABLED: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(valid_i && dis_i)); // R9

    AST_ENABLED_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        (!dis_i && valid_i) |-> valid_o); // R9

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] TMR_ADDR    = 32'h008,
    parameter logic [31:0] ECR_ADDR    = 32'h01C,
    parameter logic [31:0] MB_LO       = 32'h080,
    parameter logic [31:0] MB_HI       = 32'h17F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_disable_i,
    input  logic              cfg_loop_i,
    input  logic              cfg_listen_i,
    input  logic              eng_idle_i,
    input  logic              eng_tx_i,
    input  logic              eng_ack_slot_i,
    output logic              eng_rx_o,
    input  logic              pin_rx_i,
    output logic              pin_tx_o,
    output logic              bit0_err_o,
    output logic              cnt_freeze_o,
    output logic              force_passive_o,
    output logic              clk_en_o,
    output logic              lp_ack_o,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_rdata_i,
    output logic              acc_valid_o,
    output logic [DATA_W-1:0] acc_rdata_o,
    output logic              acc_err_o
);

    can_mode_t req;
    can_mode_t mode;

    assign req = '{dis: cfg_disable_i, loop: cfg_loop_i, listen: cfg_listen_i};

    can_mode_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .idle_i (eng_idle_i),
        .req_i  (req),
        .mode_o (mode)
    );

    can_pin_route u_route (
        .clk             (clk),
        .rst             (rst),
        .mode_i          (mode),
        .eng_tx_i        (eng_tx_i),
        .ack_slot_i      (eng_ack_slot_i),
        .pin_rx_i        (pin_rx_i),
        .pin_tx_o        (pin_tx_o),
        .eng_rx_o        (eng_rx_o),
        .bit0_err_o      (bit0_err_o),
        .cnt_freeze_o    (cnt_freeze_o),
        .force_passive_o (force_passive_o)
    );

    can_lp_hsk #(.SYNC_STAGES(SYNC_STAGES)) u_hsk (
        .clk      (clk),
        .rst      (rst),
        .dis_i    (mode.dis),
        .clk_en_o (clk_en_o),
        .lp_ack_o (lp_ack_o)
    );

    can_acc_gate #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TMR_ADDR (TMR_ADDR),
        .ECR_ADDR (ECR_ADDR),
        .MB_LO    (MB_LO),
        .MB_HI    (MB_HI)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .dis_i   (mode.dis),
        .valid_i (acc_valid_i),
        .addr_i  (acc_addr_i),
        .rdata_i (acc_rdata_i),
        .valid_o (acc_valid_o),
        .rdata_o (acc_rdata_o),
        .err_o   (acc_err_o)
    );

    AST_QUIET_PIN_IN_MODES: assert property (@(posedge clk) disable iff (rst)
        $past(eng_idle_i && (cfg_listen_i || cfg_loop_i || cfg_disable_i)) |-> pin_tx_o); // R4

    AST_LISTEN_NO_BIT0_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
        $past(eng_idle_i && cfg_loop_i) && $stable(mode) |=> !bit0_err_o); // R6

endmodule

// File: tb/can_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_mode_ctrl_tb_top;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_disable, cfg_loop, cfg_listen;
    logic              eng_idle, eng_tx, eng_ack_slot, eng_rx;
    logic              pin_rx, pin_tx;
    logic              bit0_err, cnt_freeze, force_passive, clk_en, lp_ack;
    logic              acc_valid, acc_valid_o, acc_err;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_rdata, acc_rdata_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    can_mode_ctrl dut_i (
        .clk             (clk),
        .rst             (rst),
        .cfg_disable_i   (cfg_disable),
        .cfg_loop_i      (cfg_loop),
        .cfg_listen_i    (cfg_listen),
        .eng_idle_i      (eng_idle),
        .eng_tx_i        (eng_tx),
        .eng_ack_slot_i  (eng_ack_slot),
        .eng_rx_o        (eng_rx),
        .pin_rx_i        (pin_rx),
        .pin_tx_o        (pin_tx),
        .bit0_err_o      (bit0_err),
        .cnt_freeze_o    (cnt_freeze),
        .force_passive_o (force_passive),
        .clk_en_o        (clk_en),
        .lp_ack_o        (lp_ack),
        .acc_valid_i     (acc_valid),
        .acc_addr_i      (acc_addr),
        .acc_rdata_i     (acc_rdata),
        .acc_valid_o     (acc_valid_o),
        .acc_rdata_o     (acc_rdata_o),
        .acc_err_o       (acc_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Loads a mode with the bus idle; returns at the falling edge after the loading edge.
    task automatic set_mode(logic d, logic l, logic s);
        cfg_disable = d; cfg_loop = l; cfg_listen = s; eng_idle = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        eng_tx = 1'b0;
        #1;
        chk("R7 reset clk_en", clk_en, 1);
        chk("R7 reset lp_ack", lp_ack, 0);
        chk("R7 reset bit0", bit0_err, 0);
        chk("R7 reset acc_err", acc_err, 0);
        chk("R7 reset freeze", cnt_freeze, 0);
        chk("R7 reset pin_tx", pin_tx, 0);
    endtask

    task automatic t_normal();
        eng_tx = 1'b1; pin_rx = 1'b0; #1;
        chk("R7 tx follow 1", pin_tx, 1);
        chk("R7 rx follow 0", eng_rx, 0);
        eng_tx = 1'b0; pin_rx = 1'b1; #1;
        chk("R7 tx follow 0", pin_tx, 0);
        chk("R7 rx follow 1", eng_rx, 1);
        chk("R4 no freeze", cnt_freeze, 0);
        chk("R4 no passive", force_passive, 0);
    endtask

    task automatic t_mode_sample();
        eng_tx = 1'b0;
        eng_idle = 1'b0; cfg_loop = 1'b1;
        tick();
        chk("R1 held while busy", pin_tx, 0);
        tick();
        chk("R1 still held", pin_tx, 0);
        eng_idle = 1'b1;
        tick();
        chk("R1 loaded at idle", pin_tx, 1);
        set_mode(0, 0, 0);
        chk("R1 back to normal", pin_tx, 0);
    endtask

    task automatic t_loop();
        set_mode(0, 1, 0);
        eng_tx = 1'b0; pin_rx = 1'b1; #1;
        chk("R2 rx from tx 0", eng_rx, 0);
        chk("R2 pin_tx recessive", pin_tx, 1);
        eng_tx = 1'b1; pin_rx = 1'b0; #1;
        chk("R2 rx from tx 1", eng_rx, 1);
        eng_ack_slot = 1'b1; pin_rx = 1'b1; #1;
        chk("R3 ack forced dominant", eng_rx, 0);
        tick();
        eng_ack_slot = 1'b0; #1;
        chk("R3 no bit0 in loop", bit0_err, 0);
        chk("R3 rx after slot", eng_rx, 1);
    endtask

    task automatic t_listen();
        set_mode(0, 0, 1);
        eng_tx = 1'b0; pin_rx = 1'b0; #1;
        chk("R4 pin_tx recessive", pin_tx, 1);
        chk("R4 freeze", cnt_freeze, 1);
        chk("R4 passive", force_passive, 1);
        chk("R4 rx from pin", eng_rx, 0);
        eng_ack_slot = 1'b1; pin_rx = 1'b0;
        tick();
        chk("R5 acked no error", bit0_err, 0);
        pin_rx = 1'b1;
        tick();
        eng_ack_slot = 1'b0;
        chk("R5 unacked error", bit0_err, 1);
        tick();
        chk("R5 error one cycle", bit0_err, 0);
    endtask

    task automatic t_both();
        set_mode(0, 1, 1);
        eng_tx = 1'b1; pin_rx = 1'b0; #1;
        chk("R6 rx from tx", eng_rx, 1);
        chk("R6 freeze", cnt_freeze, 1);
        chk("R6 passive", force_passive, 1);
        eng_tx = 1'b0; #1;
        chk("R6 pin_tx recessive", pin_tx, 1);
        eng_tx = 1'b1; eng_ack_slot = 1'b1; pin_rx = 1'b1; #1;
        chk("R6 ack forced", eng_rx, 0);
        tick();
        eng_ack_slot = 1'b0;
        chk("R6 no bit0", bit0_err, 0);
    endtask

    task automatic access(logic [ADDR_W-1:0] a, logic exp_fwd, string tag);
        acc_valid = 1'b1; acc_addr = a; acc_rdata = 32'hDEADBEEF; #1;
        chk(tag, acc_valid_o, exp_fwd);
        chk(tag, acc_rdata_o, exp_fwd ? 32'hDEADBEEF : 32'h0);
        tick();
        acc_valid = 1'b0;
        chk(tag, acc_err, !exp_fwd);
        tick();
        chk(tag, acc_err, 0);
    endtask

    task automatic t_disable();
        eng_tx = 1'b0;
        set_mode(1, 0, 0);
        chk("R8 clk_en drops", clk_en, 0);
        chk("R8 ack not yet e1", lp_ack, 0);
        chk("R8 pin_tx recessive", pin_tx, 1);
        tick();
        chk("R8 ack not yet e2", lp_ack, 0);
        tick();
        chk("R8 ack rises e3", lp_ack, 1);
        access(12'h008, 0, "R9 timer refused");
        access(12'h01C, 0, "R9 ecr refused");
        access(12'h080, 0, "R9 mb low refused");
        access(12'h17F, 0, "R9 mb high refused");
        access(12'h180, 1, "R9 above mb passes");
        access(12'h000, 1, "R9 config passes");
        set_mode(0, 0, 0);
        chk("R8 clk_en back", clk_en, 1);
        chk("R8 ack held e1", lp_ack, 1);
        tick();
        chk("R8 ack held e2", lp_ack, 1);
        tick();
        chk("R8 ack clears e3", lp_ack, 0);
        access(12'h008, 1, "R9 timer enabled passes");
        access(12'h100, 1, "R9 mb enabled passes");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        rst = 1'b1;
        cfg_disable = 1'b0; cfg_loop = 1'b0; cfg_listen = 1'b0;
        eng_idle = 1'b1; eng_tx = 1'b0; eng_ack_slot = 1'b0; pin_rx = 1'b1;
        acc_valid = 1'b0; acc_addr = '0; acc_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_normal();
        t_mode_sample();
        t_loop();
        t_listen();
        t_both();
        t_disable();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

endmodule